// File: doc/BRIEF.md
# USB Device Interrupt Event Register

This block gathers bus and controller events seen by a high-speed USB peripheral into a 10-bit sticky status word. It takes the following inputs:

- single-cycle strobes for bus reset, frame start, the internal pseudo frame tick, DMA status change and endpoint-0 SETUP arrival;
- two level inputs: the bus suspend state and the high-speed link flag.

The level inputs are turned into direction-specific transition events. Suspend entry, suspend exit and the full-speed to high-speed change each get their own bit. A high-speed change seen while the bus is suspended is not recorded.

Firmware reads the status word or the enable mask through a small register port. It clears status bits by writing 1 to them. A single active-high interrupt line is asserted while any status bit is set together with its enable bit. If a new event and a clear hit the same bit in the same cycle, the bit stays set, so no event is lost.

Top module: `usb_irq_status`

## Requirements
- R1: After reset, the status word, the enable mask and `irq_o` are all 0.
- R2: Status bit 0 sets on `bus_reset_i`. Bit 1 sets on `sof_i`. Bit 2 sets on `psof_i`. Bit 6 sets on `dma_chg_i`. Bit 8 sets on `ep0_setup_i`. Each bit is visible on a read one clock after the strobe is sampled.
- R3: Status bit 3 sets only when `suspend_i` changes from 0 to 1 between two clocks. Holding `suspend_i` at 1 sets nothing further.
- R4: Status bit 4 sets only when `suspend_i` changes from 1 to 0 between two clocks.
- R5: Status bit 5 sets when `hs_mode_i` changes from 0 to 1 while `suspend_i` is 0. It does not set if `suspend_i` is 1 in that cycle.
- R6: Status bits stay set until cleared. A write with `reg_sel_i`=0 clears exactly the status bits whose `reg_wdata_i` bit is 1. All other status bits are unchanged.
- R7: If a set event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R8: Bits 7 and 9 of both the status word and the enable mask always read 0, whatever is written.
- R9: A write with `reg_sel_i`=1 loads the enable mask. `reg_rdata_o` returns the enable mask when `reg_sel_i`=1 and the status word when `reg_sel_i`=0.
- R10: `irq_o` is 1 exactly when some status bit and the matching enable bit are both 1. It is 0 whenever the enable mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | Bus reset detected strobe |
| sof_i | input | 1 | Frame / microframe start received strobe |
| psof_i | input | 1 | Internal pseudo frame tick strobe |
| suspend_i | input | 1 | Bus suspend level (1 = suspended) |
| hs_mode_i | input | 1 | High-speed link level (1 = high speed) |
| dma_chg_i | input | 1 | DMA status change strobe |
| ep0_setup_i | input | 1 | SETUP received on endpoint 0 strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 enable mask |
| reg_wdata_i | input | 10 | Write data |
| reg_rdata_o | output | 10 | Read data of the selected register |
| irq_o | output | 1 | Combined interrupt output |

## Verification
On every cycle, the assertions check the following properties:

- the reserved bits stay 0;
- a strobe always leaves its status bit set on the next clock, even against a clear;
- a set status bit survives a cycle without a write;
- a suspend-entry bit never appears without a suspended input;
- the high-speed bit never rises while suspended;
- the interrupt is silent when the mask is empty.

The directed scenarios are needed to show the exact direction rules. These include a held suspend level producing no further events, and resume setting only on release. They also show that a masked-off status bit leaves `irq_o` low, and that the selective write-1 clear leaves the other bits alone.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

    localparam int unsigned ST_W = 10;

    localparam int unsigned B_BUSRST = 0;
    localparam int unsigned B_SOF    = 1;
    localparam int unsigned B_PSOF   = 2;
    localparam int unsigned B_SUSP   = 3;
    localparam int unsigned B_RESUME = 4;
    localparam int unsigned B_HS     = 5;
    localparam int unsigned B_DMA    = 6;
    localparam int unsigned B_SETUP  = 8;

    // bits that are always 0
    localparam logic [ST_W-1:0] RSV_MASK = 10'b10_1000_0000;

    typedef struct packed {
        logic bus_reset;
        logic sof;
        logic psof;
        logic susp_enter;
        logic susp_exit;
        logic hs_up;
        logic dma;
        logic setup;
    } evt_t;

    function automatic logic [ST_W-1:0] evt_to_vec(input evt_t e);
        logic [ST_W-1:0] v;
        v = '0;
        v[B_BUSRST] = e.bus_reset;
        v[B_SOF]    = e.sof;
        v[B_PSOF]   = e.psof;
        v[B_SUSP]   = e.susp_enter;
        v[B_RESUME] = e.susp_exit;
        v[B_HS]     = e.hs_up;
        v[B_DMA]    = e.dma;
        v[B_SETUP]  = e.setup;
        return v;
    endfunction

endpackage

// File: rtl/usb_lvl_track.sv
module usb_lvl_track (
    input  logic clk,
    input  logic rst,
    input  logic suspend_i,
    input  logic hs_mode_i,
    output logic susp_enter_o,
    output logic susp_exit_o,
    output logic hs_up_o
);
    logic susp_prev;
    logic hs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            susp_prev <= 1'b0;
            hs_prev   <= 1'b0;
        end else begin
            susp_prev <= suspend_i;
            hs_prev   <= hs_mode_i;
        end
    end

    always_comb begin
        susp_enter_o = suspend_i & ~susp_prev;
        susp_exit_o  = ~suspend_i & susp_prev;
        // qualified: a speed change during suspend is not a connection event
        hs_up_o      = hs_mode_i & ~hs_prev & ~suspend_i;
    end
endmodule

// File: rtl/usb_sticky_bank.sv
module usb_sticky_bank #(
    parameter int unsigned W = 10,
    parameter logic [W-1:0] RSV = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (RSV[i]) begin : g_rsv
            assign q_o[i] = 1'b0;
        end else begin : g_live
            logic b_q;
            always_ff @(posedge clk) begin
                if (rst) b_q <= 1'b0;
                else     b_q <= (b_q & ~clr_i[i]) | set_i[i];
            end
            assign q_o[i] = b_q;
        end
    end
endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate #(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] enable_i,
    output logic         irq_o
);
    assign irq_o = |(status_i & enable_i);
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
    import usb_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_reset_i,
    input  logic            sof_i,
    input  logic            psof_i,
    input  logic            suspend_i,
    input  logic            hs_mode_i,
    input  logic            dma_chg_i,
    input  logic            ep0_setup_i,
    input  logic            reg_wr_i,
    input  logic            reg_sel_i,
    input  logic [ST_W-1:0] reg_wdata_i,
    output logic [ST_W-1:0] reg_rdata_o,
    output logic            irq_o
);
    evt_t            evt;
    logic            susp_enter, susp_exit, hs_up;
    logic [ST_W-1:0] set_vec, clr_vec, status_q, enable_q;

    usb_lvl_track u_lvl (
        .clk          (clk),
        .rst          (rst),
        .suspend_i    (suspend_i),
        .hs_mode_i    (hs_mode_i),
        .susp_enter_o (susp_enter),
        .susp_exit_o  (susp_exit),
        .hs_up_o      (hs_up)
    );

    always_comb begin
        evt.bus_reset  = bus_reset_i;
        evt.sof        = sof_i;
        evt.psof       = psof_i;
        evt.susp_enter = susp_enter;
        evt.susp_exit  = susp_exit;
        evt.hs_up      = hs_up;
        evt.dma        = dma_chg_i;
        evt.setup      = ep0_setup_i;
        set_vec        = evt_to_vec(evt);
        clr_vec        = (reg_wr_i && !reg_sel_i) ? reg_wdata_i : '0;
    end

    usb_sticky_bank #(.W(ST_W), .RSV(RSV_MASK)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q_o   (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                       enable_q <= '0;
        else if (reg_wr_i && reg_sel_i) enable_q <= reg_wdata_i & ~RSV_MASK;
    end

    usb_irq_gate #(.W(ST_W)) u_gate (
        .status_i (status_q),
        .enable_i (enable_q),
        .irq_o    (irq_o)
    );

    assign reg_rdata_o = reg_sel_i ? enable_q : status_q;
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       suspend_i,
    input logic       dma_chg_i,
    input logic       reg_wr_i,
    input logic [9:0] status_q,
    input logic [9:0] enable_q,
    input logic       irq_o
);
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (status_q[7] == 1'b0) && (status_q[9] == 1'b0) &&
        (enable_q[7] == 1'b0) && (enable_q[9] == 1'b0));

    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        dma_chg_i |=> status_q[6]);

    a_r6_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (status_q[0] && !reg_wr_i) |=> status_q[0]);

    a_r3_susp_needs_level: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[3]) |-> $past(suspend_i));

    a_r5_no_hs_in_suspend: assert property (@(posedge clk) disable iff (rst)
        suspend_i |=> !$rose(status_q[5]));

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (enable_q == 10'd0) |-> !irq_o);
endmodule

bind usb_irq_status usb_irq_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .suspend_i (suspend_i),
    .dma_chg_i (dma_chg_i),
    .reg_wr_i  (reg_wr_i),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .irq_o     (irq_o)
);

// File: tb/usb_irq_status_tb.sv
module usb_irq_status_tb_top;
    localparam int CLK_HALF = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_reset_i = 0, sof_i = 0, psof_i = 0, suspend_i = 0, hs_mode_i = 0;
    logic dma_chg_i = 0, ep0_setup_i = 0, reg_wr_i = 0, reg_sel_i = 0;
    logic [9:0] reg_wdata_i = '0;
    logic [9:0] reg_rdata_o;
    logic irq_o;

    int n_chk = 0, n_bad = 0;

    always #CLK_HALF clk = ~clk;

    usb_irq_status dut_i (.*);

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic rd_status(input string req, input logic [9:0] exp);
        reg_sel_i = 0; #1; chk(req, reg_rdata_o, exp);
    endtask

    task automatic wr(input logic sel, input logic [9:0] d);
        reg_wr_i = 1; reg_sel_i = sel; reg_wdata_i = d;
        step();
        reg_wr_i = 0; reg_sel_i = 0; reg_wdata_i = '0;
    endtask

    task automatic clear_all(); wr(1'b0, 10'h3FF); endtask

    task automatic t_reset();
        rd_status("R1 status", 10'h000);
        reg_sel_i = 1; #1; chk("R1 enable", reg_rdata_o, 10'h000);
        reg_sel_i = 0;
        chk("R1 irq", {9'd0, irq_o}, 10'd0);
    endtask

    task automatic t_strobes();
        bus_reset_i = 1; step(); bus_reset_i = 0;
        rd_status("R2 bus reset bit0", 10'h001);
        sof_i = 1; psof_i = 1; step(); sof_i = 0; psof_i = 0;
        rd_status("R2 sof/psof bits1,2", 10'h007);
        dma_chg_i = 1; ep0_setup_i = 1; step(); dma_chg_i = 0; ep0_setup_i = 0;
        rd_status("R2 dma/setup bits6,8", 10'h147);
        step(); step();
        rd_status("R6 sticky hold", 10'h147);
        wr(1'b0, 10'h003);
        rd_status("R6 w1c clears bits0,1 only", 10'h144);
        clear_all();
        rd_status("R6 clear all", 10'h000);
    endtask

    task automatic t_suspend();
        suspend_i = 1; step();
        rd_status("R3 suspend entry bit3", 10'h008);
        clear_all();
        step(); step();
        rd_status("R3 held suspend no new set", 10'h000);
        suspend_i = 0; step();
        rd_status("R4 resume bit4", 10'h010);
        clear_all(); step();
        rd_status("R4 held active no new set", 10'h000);
    endtask

    task automatic t_hs();
        hs_mode_i = 1; step();
        rd_status("R5 hs up bit5", 10'h020);
        clear_all();
        hs_mode_i = 0; step();
        rd_status("R5 hs down no set", 10'h000);
        suspend_i = 1; step(); clear_all();
        hs_mode_i = 1; step();
        rd_status("R5 hs up while suspended ignored", 10'h000);
        suspend_i = 0; hs_mode_i = 0; step(); clear_all(); step();
        rd_status("R5 cleanup", 10'h000);
    endtask

    task automatic t_collide();
        dma_chg_i = 1; reg_wr_i = 1; reg_sel_i = 0; reg_wdata_i = 10'h040;
        step();
        dma_chg_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
        rd_status("R7 set wins over clear", 10'h040);
        clear_all();
    endtask

    task automatic t_reserved_irq();
        wr(1'b1, 10'h3FF);
        reg_sel_i = 1; #1; chk("R8 enable reserved read 0", reg_rdata_o, 10'h37F & 10'h17F);
        reg_sel_i = 0;
        wr(1'b1, 10'h040);
        reg_sel_i = 1; #1; chk("R9 enable readback", reg_rdata_o, 10'h040);
        reg_sel_i = 0;
        sof_i = 1; step(); sof_i = 0;
        rd_status("R8 status reserved 0", 10'h002);
        chk("R10 masked bit no irq", {9'd0, irq_o}, 10'd0);
        dma_chg_i = 1; step(); dma_chg_i = 0;
        #1 chk("R10 enabled bit irq", {9'd0, irq_o}, 10'd1);
        wr(1'b0, 10'h040);
        #1 chk("R10 cleared irq", {9'd0, irq_o}, 10'd0);
        wr(1'b1, 10'h000); clear_all();
    endtask

    initial begin
        fork
            begin
                repeat (3) step();
                rst = 0; step();
                t_reset();
                t_strobes();
                t_suspend();
                t_hs();
                t_collide();
                t_reserved_irq();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule